// File: doc/BRIEF.md
# Two-Context Parameter Switch Controller

This block keeps two complete copies of the sensor timing and gain parameters, called context A and context B. Each copy holds the same nineteen fields: integration time, line length, frame length, window start and end on both axes, odd-row and odd-column increments, row and column binning, coarse and fine analog gain, four per-colour digital gains, a global gain and a mode word. The host writes either copy at any time through a simple write port. It picks the copy the sensor should use by driving a single select level.

The select level is looked at only on frame-start pulses. A change of selection does not take effect all at once. At the first frame boundary the integration-time field moves to the new copy. At the following boundary every other field moves to it. As a result, the exposure of a frame is always programmed one frame ahead of the readout geometry and gains that go with it. The block presents the active parameter vector as one flat bus. The timing core downstream reads it directly.

Top module: `ctx_dbuf_ctrl`

## Requirements
- R1: In the first cycle after reset, both contexts hold default values and context A drives both groups (time_ctx = 0, rest_ctx = 0). The default of field i is 0x0800 + i.
- R2: Field i of the active vector is in act_params bits [16*i+15 : 16*i]. Field 0 (integration time) is read from the context given by time_ctx. Fields 1 to 18 are read from the context given by rest_ctx. A context value of 0 means A and 1 means B. Field order is: 0 integration, 1 line length, 2 frame length, 3 x start, 4 y start, 5 x end, 6 y end, 7 x odd increment, 8 y odd increment, 9 row binning, 10 column binning, 11 coarse gain, 12 fine gain, 13 green-red gain, 14 blue gain, 15 red gain, 16 green-blue gain, 17 global gain, 18 mode.
- R3: Suppose frame_start is high, no switch is pending (time_ctx equals rest_ctx) and ctx_sel differs from time_ctx. Then time_ctx takes the value of ctx_sel, and this is visible in the cycle after that clock edge. rest_ctx keeps its value.
- R4: Suppose frame_start is high while a switch is pending. Then rest_ctx takes the value of time_ctx, which completes the switch.
- R5: Switching from A to B and from B to A follow the same two-boundary sequence.
- R6: ctx_sel has no effect between frame-start pulses. A change that is reversed before the next pulse produces no switch.
- R7: ctx_sel is ignored on the pulse that completes a pending switch. If it still differs from time_ctx at the next pulse, a new switch starts there.
- R8: With wr_en high, field wr_addr of the context given by wr_ctx (0 = A, 1 = B) is set to wr_data. If the group of that field currently reads that context, the new value shows on act_params in the next cycle.
- R9: A write to a context that the written field's group does not read leaves act_params unchanged. The value appears once a switch moves that group to the context.
- R10: A write with wr_addr of 19 or more changes no field of either context.
- R11: A write and a frame-start pulse in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| frame_start | input | 1 | One-cycle pulse marking a frame boundary |
| ctx_sel | input | 1 | Requested context, 0 = A, 1 = B |
| wr_en | input | 1 | Field write strobe |
| wr_ctx | input | 1 | Context written, 0 = A, 1 = B |
| wr_addr | input | 5 | Field index written |
| wr_data | input | 16 | Field value written |
| act_params | output | 304 | Active parameter vector, 19 fields of 16 bits |
| time_ctx | output | 1 | Context read by the integration-time field |
| rest_ctx | output | 1 | Context read by all other fields |

## Verification
The directed part of the bench covers several cases. A select change made without a frame pulse shows that the select is sampled only at boundaries. A change that is undone before the pulse shows that such changes cancel. Two successive pulses separate the integration-time step from the step for the other fields, and this is run in both directions. A select reversal placed inside a pending switch shows that new requests are queued and not merged. Writes to the unused copy, to out-of-range indices, and writes in the same cycle as a pulse separate storage updates from output updates. Random traffic then mixes pulses, select flips and writes, and compares every field with a reference model after every cycle.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

    localparam int CS_NPARAM = 19;
    localparam int CS_PW     = 16;
    localparam int CS_AW     = $clog2(CS_NPARAM);
    localparam int CS_NCTX   = 2;

    typedef enum logic {
        CTX_A = 1'b0,
        CTX_B = 1'b1
    } ctx_e;

    typedef enum logic [CS_AW-1:0] {
        F_INTEG    = 5'd0,
        F_LINE_LEN = 5'd1,
        F_FRM_LEN  = 5'd2,
        F_X_LO     = 5'd3,
        F_Y_LO     = 5'd4,
        F_X_HI     = 5'd5,
        F_Y_HI     = 5'd6,
        F_X_STEP   = 5'd7,
        F_Y_STEP   = 5'd8,
        F_ROW_BIN  = 5'd9,
        F_COL_BIN  = 5'd10,
        F_CGAIN    = 5'd11,
        F_FGAIN    = 5'd12,
        F_GAIN_GR  = 5'd13,
        F_GAIN_B   = 5'd14,
        F_GAIN_R   = 5'd15,
        F_GAIN_GB  = 5'd16,
        F_GAIN_ALL = 5'd17,
        F_MODE     = 5'd18
    } field_e;

    // Which context each of the two field groups reads.
    typedef struct packed {
        ctx_e time_grp;
        ctx_e rest_grp;
    } ctx_state_t;

    function automatic logic [31:0] cs_default(input int idx);
        return 32'h0000_0800 + 32'(idx);
    endfunction

endpackage

// File: rtl/ctxsw_bank.sv
module ctxsw_bank
    import ctxsw_pkg::*;
#(
    parameter int NP = CS_NPARAM,
    parameter int PW = CS_PW,
    parameter int AW = CS_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [PW-1:0]    wdata,
    output logic [NP*PW-1:0] fields
);

    generate
        for (genvar i = 0; i < NP; i++) begin : g_field
            always_ff @(posedge clk) begin
                if (rst) begin
                    fields[i*PW +: PW] <= PW'(cs_default(i));
                end else if (we && (waddr == AW'(i))) begin
                    fields[i*PW +: PW] <= wdata;
                end
            end
        end
    endgenerate

    // R10: an index past the last field touches nothing
    a_r10_bad_index_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && (int'(waddr) >= NP)) |=> $stable(fields));

    // R9: storage only moves on a write strobe
    a_r9_hold_without_write: assert property (@(posedge clk) disable iff (rst)
        !we |=> $stable(fields));

endmodule

// File: rtl/ctxsw_seq.sv
module ctxsw_seq
    import ctxsw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_start,
    input  logic       ctx_sel,
    output ctx_state_t state
);

    ctx_state_t state_q, state_d;
    logic       pending;
    ctx_e       req;

    assign req     = ctx_e'(ctx_sel);
    assign pending = (state_q.time_grp != state_q.rest_grp);

    always_comb begin
        state_d = state_q;
        if (frame_start) begin
            if (pending) begin
                state_d.rest_grp = state_q.time_grp;
            end else if (req != state_q.time_grp) begin
                state_d.time_grp = req;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '{time_grp: CTX_A, rest_grp: CTX_A};
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

    // R6: nothing moves between frame boundaries
    a_r6_hold_between_frames: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> $stable(state_q));

    // R3: a fresh request moves only the integration group
    a_r3_time_first: assert property (@(posedge clk) disable iff (rst)
        (frame_start && (state_q.time_grp == state_q.rest_grp)
            && (ctx_e'(ctx_sel) != state_q.time_grp))
        |=> (state_q.time_grp == ctx_e'($past(ctx_sel)))
            && $stable(state_q.rest_grp));

    // R4: the next boundary brings the remaining fields along
    a_r4_rest_follows: assert property (@(posedge clk) disable iff (rst)
        (frame_start && (state_q.time_grp != state_q.rest_grp))
        |=> (state_q.rest_grp == $past(state_q.time_grp)));

    // R7: the completing boundary never starts another switch
    a_r7_queue_behind_pending: assert property (@(posedge clk) disable iff (rst)
        (frame_start && (state_q.time_grp != state_q.rest_grp))
        |=> $stable(state_q.time_grp));

endmodule

// File: rtl/ctxsw_mux.sv
module ctxsw_mux
    import ctxsw_pkg::*;
#(
    parameter int NP = CS_NPARAM,
    parameter int PW = CS_PW
) (
    input  logic [NP*PW-1:0] bank_a,
    input  logic [NP*PW-1:0] bank_b,
    input  ctx_state_t       state,
    output logic [NP*PW-1:0] active
);

    generate
        for (genvar i = 0; i < NP; i++) begin : g_sel
            if (i == int'(F_INTEG)) begin : g_time
                assign active[i*PW +: PW] = (state.time_grp == CTX_B)
                    ? bank_b[i*PW +: PW] : bank_a[i*PW +: PW];
            end else begin : g_rest
                assign active[i*PW +: PW] = (state.rest_grp == CTX_B)
                    ? bank_b[i*PW +: PW] : bank_a[i*PW +: PW];
            end
        end
    endgenerate

endmodule

// File: rtl/ctx_dbuf_ctrl.sv
module ctx_dbuf_ctrl
    import ctxsw_pkg::*;
#(
    parameter int NP = CS_NPARAM,
    parameter int PW = CS_PW,
    parameter int AW = CS_AW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             ctx_sel,
    input  logic             wr_en,
    input  logic             wr_ctx,
    input  logic [AW-1:0]    wr_addr,
    input  logic [PW-1:0]    wr_data,
    output logic [NP*PW-1:0] act_params,
    output logic             time_ctx,
    output logic             rest_ctx
);

    localparam int NCTX = CS_NCTX;

    logic [NP*PW-1:0] bank_q [NCTX];
    ctx_state_t       st;

    generate
        for (genvar c = 0; c < NCTX; c++) begin : g_bank
            ctxsw_bank #(.NP(NP), .PW(PW), .AW(AW)) u_bank (
                .clk    (clk),
                .rst    (rst),
                .we     (wr_en && (wr_ctx == 1'(c))),
                .waddr  (wr_addr),
                .wdata  (wr_data),
                .fields (bank_q[c])
            );
        end
    endgenerate

    ctxsw_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .ctx_sel     (ctx_sel),
        .state       (st)
    );

    ctxsw_mux #(.NP(NP), .PW(PW)) u_mux (
        .bank_a (bank_q[0]),
        .bank_b (bank_q[1]),
        .state  (st),
        .active (act_params)
    );

    assign time_ctx = logic'(st.time_grp);
    assign rest_ctx = logic'(st.rest_grp);

    // R9: a write aimed only at the unread copy leaves the outputs alone
    a_r9_inactive_write_hidden: assert property (@(posedge clk) disable iff (rst)
        (!frame_start && !(wr_en && ((wr_ctx == time_ctx) || (wr_ctx == rest_ctx))))
        |=> $stable(act_params));

    generate
        for (genvar i = 0; i < NP; i++) begin : g_chk
            // R8: a write to the copy its group reads shows up one cycle later
            a_r8_active_write_seen: assert property (@(posedge clk) disable iff (rst)
                (wr_en && !frame_start && (wr_addr == AW'(i))
                    && (wr_ctx == ((i == 0) ? time_ctx : rest_ctx)))
                |=> (act_params[i*PW +: PW] == $past(wr_data)));
        end
    endgenerate

endmodule

// File: tb/ctx_dbuf_ctrl_tb.sv
module ctx_dbuf_ctrl_tb;

    localparam int NP = 19;
    localparam int PW = 16;
    localparam int AW = 5;

    logic             clk = 1'b0;
    logic             rst;
    logic             frame_start;
    logic             ctx_sel;
    logic             wr_en;
    logic             wr_ctx;
    logic [AW-1:0]    wr_addr;
    logic [PW-1:0]    wr_data;
    logic [NP*PW-1:0] act_params;
    logic             time_ctx;
    logic             rest_ctx;

    always #10 clk = ~clk;

    ctx_dbuf_ctrl u_dut (
        .clk(clk), .rst(rst), .frame_start(frame_start), .ctx_sel(ctx_sel),
        .wr_en(wr_en), .wr_ctx(wr_ctx), .wr_addr(wr_addr), .wr_data(wr_data),
        .act_params(act_params), .time_ctx(time_ctx), .rest_ctx(rest_ctx)
    );

    logic [PW-1:0] mdl [2][NP];
    logic          m_time, m_rest;
    int            checks = 0;
    int            errors = 0;
    logic          sel_now = 1'b0;

    task automatic model_reset();
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < NP; i++)
                mdl[c][i] = 16'h0800 + 16'(i);
        m_time = 1'b0;
        m_rest = 1'b0;
    endtask

    // Reference for one clock edge, written from R3, R4, R7, R8, R10, R11
    task automatic model_edge();
        if (frame_start) begin
            if (m_time != m_rest) m_rest = m_time;
            else if (ctx_sel != m_time) m_time = ctx_sel;
        end
        if (wr_en && (int'(wr_addr) < NP))
            mdl[wr_ctx][wr_addr] = wr_data;
    endtask

    function automatic logic [PW-1:0] expect_field(input int i);
        return mdl[(i == 0) ? m_time : m_rest][i];
    endfunction

    task automatic compare(input string tag);
        logic bad = 1'b0;
        checks++;
        if (time_ctx !== m_time || rest_ctx !== m_rest) begin
            bad = 1'b1;
            $display("FAIL %s: contexts time/rest got %0b/%0b expected %0b/%0b",
                     tag, time_ctx, rest_ctx, m_time, m_rest);
        end
        for (int i = 0; i < NP; i++) begin
            if (!bad && act_params[i*PW +: PW] !== expect_field(i)) begin
                bad = 1'b1;
                $display("FAIL %s: field %0d got %h expected %h",
                         tag, i, act_params[i*PW +: PW], expect_field(i));
            end
        end
        if (bad) errors++;
    endtask

    task automatic step(input logic fs, input logic sel, input logic we,
                        input logic wc, input logic [AW-1:0] a,
                        input logic [PW-1:0] d, input string tag);
        frame_start = fs;
        ctx_sel     = sel;
        wr_en       = we;
        wr_ctx      = wc;
        wr_addr     = a;
        wr_data     = d;
        sel_now     = sel;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input string tag);
        step(1'b0, sel_now, 1'b0, 1'b0, '0, '0, tag);
    endtask

    task automatic pulse(input logic sel, input string tag);
        step(1'b1, sel, 1'b0, 1'b0, '0, '0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stimulus
        void'($urandom(32'd20240611));
        rst = 1'b1; frame_start = 1'b0; ctx_sel = 1'b0;
        wr_en = 1'b0; wr_ctx = 1'b0; wr_addr = '0; wr_data = '0;
        repeat (3) @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        compare("R1 reset defaults");
        idle("R1 hold after reset");

        // R9: writes to B while A is in use stay hidden
        step(1'b0, 1'b0, 1'b1, 1'b1, 5'd0,  16'hB000, "R9 inactive integ write");
        step(1'b0, 1'b0, 1'b1, 1'b1, 5'd7,  16'hB007, "R9 inactive field write");
        // R8: writes to A show next cycle
        step(1'b0, 1'b0, 1'b1, 1'b0, 5'd3,  16'hA003, "R8 active write");
        step(1'b0, 1'b0, 1'b1, 1'b0, 5'd0,  16'hA000, "R8 active integ write");

        // R6: select with no pulse does nothing
        step(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R6 select between pulses");
        idle("R6 still no switch");
        // R3 then R4, A to B
        pulse(1'b1, "R3 integ moves to B");
        idle("R3 rest still A");
        pulse(1'b1, "R4 rest moves to B");
        idle("R5 settled on B");

        // R6: toggle and back inside a frame
        step(1'b0, 1'b0, 1'b0, 1'b0, '0, '0, "R6 toggle away");
        step(1'b0, 1'b1, 1'b0, 1'b0, '0, '0, "R6 toggle back");
        pulse(1'b1, "R6 cancelled toggle no switch");

        // R5: B to A
        pulse(1'b0, "R5 integ back to A");
        pulse(1'b0, "R5 rest back to A");

        // R7: request reversed while pending
        pulse(1'b1, "R7 start switch to B");
        pulse(1'b0, "R7 completing pulse ignores select");
        idle("R7 pending request held");
        pulse(1'b0, "R7 queued switch starts");
        pulse(1'b0, "R7 queued switch completes");

        // R10: out-of-range indices
        step(1'b0, 1'b0, 1'b1, 1'b0, 5'd19, 16'hDEAD, "R10 index 19 ignored");
        step(1'b0, 1'b0, 1'b1, 1'b0, 5'd31, 16'hBEEF, "R10 index 31 ignored");

        // R11: write and pulse together
        pulse(1'b1, "R11 begin switch");
        step(1'b1, 1'b1, 1'b1, 1'b1, 5'd2, 16'h5A5A, "R11 write with completing pulse");
        step(1'b1, 1'b0, 1'b1, 1'b1, 5'd0, 16'h1234, "R11 write with starting pulse");
        idle("R11 after");

        // R2: random mix
        for (int n = 0; n < 1500; n++) begin
            logic fs, we, wc;
            logic [AW-1:0] a;
            logic [PW-1:0] d;
            fs = (($urandom % 8) == 0);
            if (($urandom % 10) == 0) sel_now = ~sel_now;
            we = (($urandom % 3) == 0);
            wc = 1'($urandom);
            a  = AW'($urandom % 24);
            d  = PW'($urandom);
            step(fs, sel_now, we, wc, a, d, "R2 random traffic");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule